// File: doc/BRIEF.md
# Detector Ring Sum/Difference Time Binner

This block reduces a stream of parallel detector samples to a compact per-pulse record. Forty-eight unsigned channels arrive together on one wide bus, grouped as four rings of twelve detectors. For each accepted sample the block forms the rounded mean of every ring. It also forms, for every detector, the signed offset of that detector from its own ring's mean. Neither result is stored raw. Both are integrated into time bins instead.

The ring means go to a "sum" path whose bins each span 25 consecutive accepted samples. The per-detector offsets go to a "difference" path whose bins each span 20. Each path produces 100 bins per pulse. A pulse-start strobe opens a new pulse. When a bin closes, its channel totals appear on that path's own result port together with the bin index. After its hundredth bin, a path stays quiet until the next strobe.

Top module: `det_ring_binner`

## Requirements
- R1: Detector d (0..47) is read from `smp_bus[d*12 +: 12]` as an unsigned value and belongs to ring d/12. Difference channel d and ring r use the same numbering in the result buses.
- R2: The mean of a ring equals floor((S + 6) / 12), where S is the sum of its twelve samples. This is round-to-nearest, with halves rounded up.
- R3: The difference value of a detector equals its sample minus the mean of its own ring, as a signed quantity.
- R4: A sum bin holds the total of the ring means over 25 accepted samples, and a difference bin holds the total over 20. Each total is an 18-bit two's-complement value, and it is exact even when every input is 4095.
- R5: A path asserts its valid output for exactly one cycle. That cycle follows the clock edge that accepted the bin's last sample. The bin index counts 0, 1, ... 99 within a pulse.
- R6: Once bin 99 of a path has closed, that path accepts no samples and produces no output until the next start strobe.
- R7: A start strobe clears all totals and both bin counters, so any partly filled bins are dropped. A sample that is valid in the same cycle as the strobe is the first sample of the new pulse.
- R8: After reset, samples are ignored until the first start strobe.
- R9: Cycles with `smp_valid` low neither add to the totals nor advance the counters.
- R10: During and just after reset both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_start | input | 1 | Opens a new pulse |
| smp_valid | input | 1 | The sample bus holds a sample this cycle |
| smp_bus | input | 576 | 48 unsigned 12-bit detector samples |
| sum_valid | output | 1 | A sum bin has closed |
| sum_bin | output | 7 | Index of the closed sum bin |
| sum_data | output | 72 | Four 18-bit signed ring-mean totals, ring r at [r*18 +: 18] |
| diff_valid | output | 1 | A difference bin has closed |
| diff_bin | output | 7 | Index of the closed difference bin |
| diff_data | output | 864 | 48 18-bit signed offset totals, detector d at [d*18 +: 18] |

## Verification
The bench drives ring sums that sit exactly on a half (S mod 12 = 6). A design that truncated, or that used a reciprocal that was too coarse, would give means one step low there. It runs full pulses far past bin 99 on both paths. A design that failed to stop would emit a bin 100 or wrap back to index 0. It restarts a pulse with bins half full and checks that the next bin 0 holds only new samples. Stale totals or a counter that was not cleared would show as wrong sums or a late first bin. It also covers full-scale input, where a narrow total would wrap negative, and it checks that samples taken before the first strobe and gapped samples leave no trace in the totals.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // Fixed-point reciprocal of n with f fraction bits, rounded up so that
  // the scaled product never falls below the true quotient.
  function automatic logic [63:0] recip_const(input int unsigned n, input int unsigned f);
    return ((64'd1 << f) + 64'(n) - 64'd1) / 64'(n);
  endfunction

  // Nearest-integer mean of a total over n items, halves rounded up.
  function automatic logic [63:0] scaled_mean(input logic [63:0] total,
                                              input int unsigned n,
                                              input int unsigned f);
    logic [63:0] k;
    k = recip_const(n, f);
    return ((total + 64'(n / 2)) * k) >> f;
  endfunction

  // Signed accumulator width for len additions of an in_w-bit signed value.
  function automatic int unsigned acc_width(input int unsigned in_w, input int unsigned len);
    return in_w + $clog2(len);
  endfunction

endpackage

// File: rtl/dring_ring_mean.sv
module dring_ring_mean
  import dring_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int N_DET   = 12,
  parameter int RECIP_F = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_DET*SMP_W-1:0]       smp,
  output logic [SMP_W-1:0]             avg,
  output logic [N_DET*(SMP_W+1)-1:0]   dev
);
  localparam int SUM_W = SMP_W + $clog2(N_DET);
  localparam int CHK_W = SUM_W + 2;

  logic [SUM_W-1:0] ring_sum;
  logic [63:0]      mean_wide;

  always_comb begin
    ring_sum = '0;
    for (int i = 0; i < N_DET; i++) begin
      ring_sum = ring_sum + SUM_W'(smp[i*SMP_W +: SMP_W]);
    end
  end

  assign mean_wide = scaled_mean(64'(ring_sum), N_DET, RECIP_F);
  assign avg       = mean_wide[SMP_W-1:0];

  for (genvar i = 0; i < N_DET; i++) begin : g_dev
    assign dev[i*(SMP_W+1) +: (SMP_W+1)] =
      {1'b0, smp[i*SMP_W +: SMP_W]} - {1'b0, avg};
  end

  // Checks of the reciprocal approximation against the exact ring sum.
  logic [CHK_W-1:0] biased_sum, mean_times_n;
  assign biased_sum   = CHK_W'(ring_sum) + CHK_W'(N_DET / 2);
  assign mean_times_n = CHK_W'(avg) * CHK_W'(N_DET);

  p_mean_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mean_wide < (64'd1 << SMP_W));
  p_mean_rounding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (biased_sum >= mean_times_n) && ((biased_sum - mean_times_n) < CHK_W'(N_DET)));

endmodule

// File: rtl/dring_bin_path.sv
module dring_bin_path #(
  parameter int N_CHAN = 4,
  parameter int IN_W   = 13,
  parameter int ACC_W  = 18,
  parameter int LEN    = 25,
  parameter int N_BINS = 100,
  parameter int BIN_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      in_valid,
  input  logic [N_CHAN*IN_W-1:0]    in_data,
  output logic                      out_valid,
  output logic [BIN_W-1:0]          out_bin,
  output logic [N_CHAN*ACC_W-1:0]   out_data
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt, eff_cnt;
  logic [BIN_W-1:0] bin, eff_bin;
  logic             active, eff_active;
  logic             take, bin_close, last_bin;

  // A start strobe replaces the current state in the same cycle.
  assign eff_cnt    = start ? '0 : cnt;
  assign eff_bin    = start ? '0 : bin;
  assign eff_active = start | active;
  assign take       = in_valid & eff_active;
  assign bin_close  = take && (eff_cnt == CNT_W'(LEN - 1));
  assign last_bin   = bin_close && (eff_bin == BIN_W'(N_BINS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      bin       <= '0;
      out_valid <= 1'b0;
      out_bin   <= '0;
    end else begin
      out_valid <= bin_close;
      active    <= last_bin ? 1'b0 : eff_active;
      if (take) begin
        cnt <= bin_close ? '0 : eff_cnt + CNT_W'(1);
      end else begin
        cnt <= eff_cnt;
      end
      if (bin_close) begin
        out_bin <= eff_bin;
        bin     <= last_bin ? '0 : eff_bin + BIN_W'(1);
      end else begin
        bin <= eff_bin;
      end
    end
  end

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    logic [ACC_W-1:0] acc, eff_acc, x, nxt, res;
    logic [ACC_W:0]   wide;

    assign x       = {{(ACC_W-IN_W){in_data[ch*IN_W+IN_W-1]}}, in_data[ch*IN_W +: IN_W]};
    assign eff_acc = start ? '0 : acc;
    assign wide    = {eff_acc[ACC_W-1], eff_acc} + {x[ACC_W-1], x};
    assign nxt     = wide[ACC_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= '0;
        res <= '0;
      end else begin
        if (take) begin
          acc <= bin_close ? '0 : nxt;
        end else begin
          acc <= eff_acc;
        end
        if (bin_close) begin
          res <= nxt;
        end
      end
    end

    assign out_data[ch*ACC_W +: ACC_W] = res;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (wide[ACC_W] == wide[ACC_W-1]));
  end

  p_bin_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bin < BIN_W'(N_BINS)));
  p_quiet_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !out_valid);
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> (cnt == '0 && bin == '0 && active));
  p_single_cycle_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && LEN > 1) |=> !out_valid);

endmodule

// File: rtl/det_ring_binner.sv
module det_ring_binner
  import dring_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int N_RING   = 4,
  parameter int N_DET    = 12,
  parameter int SUM_LEN  = 25,
  parameter int DIFF_LEN = 20,
  parameter int N_BINS   = 100,
  parameter int RECIP_F  = 20,
  localparam int N_CH    = N_RING * N_DET,
  localparam int IN_W    = SMP_W + 1,
  localparam int SACC_W  = acc_width(IN_W, SUM_LEN),
  localparam int DACC_W  = acc_width(IN_W, DIFF_LEN),
  localparam int BIN_W   = (N_BINS > 1) ? $clog2(N_BINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pulse_start,
  input  logic                       smp_valid,
  input  logic [N_CH*SMP_W-1:0]      smp_bus,
  output logic                       sum_valid,
  output logic [BIN_W-1:0]           sum_bin,
  output logic [N_RING*SACC_W-1:0]   sum_data,
  output logic                       diff_valid,
  output logic [BIN_W-1:0]           diff_bin,
  output logic [N_CH*DACC_W-1:0]     diff_data
);
  logic [N_RING*IN_W-1:0] mean_flat;
  logic [N_CH*IN_W-1:0]   dev_flat;

  for (genvar r = 0; r < N_RING; r++) begin : g_ring
    logic [SMP_W-1:0] ring_avg;

    dring_ring_mean #(
      .SMP_W   (SMP_W),
      .N_DET   (N_DET),
      .RECIP_F (RECIP_F)
    ) u_mean (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (smp_bus[r*N_DET*SMP_W +: N_DET*SMP_W]),
      .avg   (ring_avg),
      .dev   (dev_flat[r*N_DET*IN_W +: N_DET*IN_W])
    );

    assign mean_flat[r*IN_W +: IN_W] = {1'b0, ring_avg};
  end

  dring_bin_path #(
    .N_CHAN (N_RING),
    .IN_W   (IN_W),
    .ACC_W  (SACC_W),
    .LEN    (SUM_LEN),
    .N_BINS (N_BINS),
    .BIN_W  (BIN_W)
  ) u_sum_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pulse_start),
    .in_valid  (smp_valid),
    .in_data   (mean_flat),
    .out_valid (sum_valid),
    .out_bin   (sum_bin),
    .out_data  (sum_data)
  );

  dring_bin_path #(
    .N_CHAN (N_CH),
    .IN_W   (IN_W),
    .ACC_W  (DACC_W),
    .LEN    (DIFF_LEN),
    .N_BINS (N_BINS),
    .BIN_W  (BIN_W)
  ) u_diff_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pulse_start),
    .in_valid  (smp_valid),
    .in_data   (dev_flat),
    .out_valid (diff_valid),
    .out_bin   (diff_bin),
    .out_data  (diff_data)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!sum_valid && !diff_valid));

endmodule

// File: tb/det_ring_binner_bench.sv
module det_ring_binner_bench;
  localparam int CLK_P    = 10;
  localparam int SMP_W    = 12;
  localparam int N_RING   = 4;
  localparam int N_DET    = 12;
  localparam int N_CH     = 48;
  localparam int SUM_LEN  = 25;
  localparam int DIFF_LEN = 20;
  localparam int N_BINS   = 100;
  localparam int SW       = 18;
  localparam int DW       = 18;
  localparam int BW       = 7;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   pulse_start = 1'b0;
  logic                   smp_valid = 1'b0;
  logic [N_CH*SMP_W-1:0]  smp_bus = '0;
  logic                   sum_valid, diff_valid;
  logic [BW-1:0]          sum_bin, diff_bin;
  logic [N_RING*SW-1:0]   sum_data;
  logic [N_CH*DW-1:0]     diff_data;

  always #(CLK_P/2) clk = ~clk;

  det_ring_binner u_det_ring_binner (
    .clk (clk), .rst_n (rst_n), .pulse_start (pulse_start), .smp_valid (smp_valid),
    .smp_bus (smp_bus), .sum_valid (sum_valid), .sum_bin (sum_bin), .sum_data (sum_data),
    .diff_valid (diff_valid), .diff_bin (diff_bin), .diff_data (diff_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int smp [N_CH];

  // Reference model state
  int ms_acc [N_RING];
  int md_acc [N_CH];
  int ms_cnt = 0, md_cnt = 0, ms_bin = 0, md_bin = 0;
  bit ms_act = 0, md_act = 0;
  bit e_sv, e_dv;
  int e_sbin, e_dbin;
  int e_sd [N_RING];
  int e_dd [N_CH];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fill(input int mode, input int k);
    for (int c = 0; c < N_CH; c++) begin
      case (mode)
        0: smp[c] = int'($urandom % 4096);
        1: smp[c] = 4095;
        2: smp[c] = (c % N_DET == 0) ? 6 + 12 * int'($urandom % 341) : 12 * int'($urandom % 341);
        default: smp[c] = (c == k % N_CH) ? 4095 : 0;
      endcase
    end
  endtask

  task automatic model(input bit st, input bit vld);
    int av [N_RING];
    e_sv = 0;
    e_dv = 0;
    if (st) begin
      for (int r = 0; r < N_RING; r++) ms_acc[r] = 0;
      for (int c = 0; c < N_CH; c++) md_acc[c] = 0;
      ms_cnt = 0; md_cnt = 0; ms_bin = 0; md_bin = 0;
      ms_act = 1; md_act = 1;
    end
    if (vld) begin
      for (int r = 0; r < N_RING; r++) begin
        int s;
        s = 0;
        for (int i = 0; i < N_DET; i++) s += smp[r*N_DET + i];
        av[r] = (s + 6) / 12;
      end
      if (ms_act) begin
        for (int r = 0; r < N_RING; r++) ms_acc[r] += av[r];
        ms_cnt++;
        if (ms_cnt == SUM_LEN) begin
          e_sv = 1; e_sbin = ms_bin;
          for (int r = 0; r < N_RING; r++) begin e_sd[r] = ms_acc[r]; ms_acc[r] = 0; end
          ms_cnt = 0; ms_bin++;
          if (ms_bin == N_BINS) ms_act = 0;
        end
      end
      if (md_act) begin
        for (int c = 0; c < N_CH; c++) md_acc[c] += smp[c] - av[c / N_DET];
        md_cnt++;
        if (md_cnt == DIFF_LEN) begin
          e_dv = 1; e_dbin = md_bin;
          for (int c = 0; c < N_CH; c++) begin e_dd[c] = md_acc[c]; md_acc[c] = 0; end
          md_cnt = 0; md_bin++;
          if (md_bin == N_BINS) md_act = 0;
        end
      end
    end
  endtask

  task automatic step(input bit st, input bit vld, input string tag);
    for (int c = 0; c < N_CH; c++) smp_bus[c*SMP_W +: SMP_W] = SMP_W'(smp[c]);
    pulse_start = st;
    smp_valid   = vld;
    model(st, vld);
    @(posedge clk);
    @(negedge clk);
    chk(sum_valid == e_sv, tag, "sum_valid (R5)", int'(sum_valid), int'(e_sv));
    chk(diff_valid == e_dv, tag, "diff_valid (R5)", int'(diff_valid), int'(e_dv));
    if (e_sv && sum_valid) begin
      chk(int'(sum_bin) == e_sbin, tag, "sum_bin index (R5)", int'(sum_bin), e_sbin);
      for (int r = 0; r < N_RING; r++) begin
        int a;
        a = int'($signed(sum_data[r*SW +: SW]));
        chk(a == e_sd[r], tag, $sformatf("R2/R4 sum total ring %0d", r), a, e_sd[r]);
      end
    end
    if (e_dv && diff_valid) begin
      chk(int'(diff_bin) == e_dbin, tag, "diff_bin index (R5)", int'(diff_bin), e_dbin);
      for (int c = 0; c < N_CH; c++) begin
        int a;
        a = int'($signed(diff_data[c*DW +: DW]));
        chk(a == e_dd[c], tag, $sformatf("R1/R3 diff total det %0d", c), a, e_dd[c]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < N_CH; c++) smp[c] = 0;
    repeat (3) @(negedge clk);
    chk(sum_valid == 1'b0, "R10", "sum_valid in reset", int'(sum_valid), 0);
    chk(diff_valid == 1'b0, "R10", "diff_valid in reset", int'(diff_valid), 0);
    rst_n = 1'b1;
    step(0, 0, "R10");

    // R8: samples before any start strobe
    for (int i = 0; i < 30; i++) begin fill(0, i); step(0, 1, "R8"); end

    // R5/R6: full pulse run well past both paths' last bin (start with valid sample: R7)
    for (int i = 0; i < 2560; i++) begin
      fill(0, i);
      step(i == 0, 1, (i < 2000) ? "R5" : "R6");
    end

    // R7: restart while bins are part-filled
    for (int i = 0; i < 45; i++) begin fill(0, i); step(i == 0, 1, "R7"); end
    for (int i = 0; i < 60; i++) begin fill(0, i); step(i == 0, 1, "R7"); end

    // R9: gapped samples
    for (int i = 0; i < 300; i++) begin fill(0, i); step(i == 0, (i % 3) != 0, "R9"); end

    // R2: every ring sum lands on a half step
    for (int i = 0; i < 200; i++) begin fill(2, i); step(i == 0, 1, "R2"); end

    // R3: one hot detector walking across all channels
    for (int i = 0; i < 200; i++) begin fill(3, i); step(i == 0, 1, "R3"); end

    // R4: full-scale input through a complete pulse
    for (int i = 0; i < 2560; i++) begin fill(1, i); step(i == 0, 1, "R4"); end

    for (int i = 0; i < 5; i++) begin fill(0, i); step(0, 0, "R6"); end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule